// File: doc/BRIEF.md
# Packed Subword Integer ALU

This block performs one integer operation per cycle on a pair of 64-bit source vectors. Each vector is treated as a row of independent elements, all 8, 16 or 32 bits wide. The available operations are lane-wise add and subtract, with either wraparound or clamping on overflow, and lane-wise equality and greater-than tests that return full-lane masks. There are also two interleaving operations that merge the lower or upper halves of the two sources, and a narrowing pack that squeezes both sources into elements of half the width with saturation.

A caller presents the opcode, the element size, the saturation and signedness controls and both sources, together with a valid strobe. The result is captured in an output register one clock edge later, and an output valid marks it. When no valid input arrives, the register keeps its last value.

Top module: `psalu_top`

## Requirements
- R1: `out_valid` equals the value that `in_valid` had at the previous rising clock edge. A result requested in one cycle appears on `result` after exactly one rising edge.
- R2: While `in_valid` is low, `result` keeps its previous value, whatever the other inputs are.
- R3: Add (opcode 0) and subtract (opcode 1) with `sat_en`=0 wrap modulo 2^W within each lane. No carry or borrow crosses a lane boundary. `lane_sz` selects W: 0 gives 8, 1 gives 16, 2 gives 32.
- R4: With `sat_en`=1 and `signed_en`=1, a lane whose add or subtract overflows is clamped to the most positive or most negative two's-complement value of W bits, matching the true sign of the exact result.
- R5: With `sat_en`=1 and `signed_en`=0, an unsigned add that overflows gives all ones in that lane, and an unsigned subtract that goes below zero gives zero.
- R6: Compare-equal (opcode 2) writes all ones into each lane whose two elements are equal and all zeros into the others.
- R7: Compare-greater (opcode 3) writes all ones into each lane where the first source element is greater than the second. The comparison is signed when `signed_en`=1 and unsigned otherwise. Other lanes get all zeros.
- R8: Unpack-low (opcode 4) fills the result with the lower-half elements of both sources interleaved. Result element 2k is element k of `src_a`, and result element 2k+1 is element k of `src_b`.
- R9: Unpack-high (opcode 5) does the same with the upper-half elements. For N lanes, result element 2k is element N/2+k of `src_a`, and result element 2k+1 is element N/2+k of `src_b`.
- R10: Pack (opcode 6) with `lane_sz` 1 or 2 narrows each element to half its width. The narrowed `src_a` elements fill the lower 32 bits and the narrowed `src_b` elements fill the upper 32 bits, each group in its original order. With `signed_en`=1, elements are clamped to the signed range of the narrower width.
- R11: Pack with `signed_en`=0 treats the source elements as unsigned. Any element above the narrow all-ones value becomes all ones.
- R12: Opcode 7, `lane_sz` 3, and pack with `lane_sz` 0 all give a zero result.
- R13: While `rst_n` is low, `out_valid` and `result` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| opcode | input | 3 | Operation: 0 add, 1 sub, 2 eq, 3 gt, 4 unpack-low, 5 unpack-high, 6 pack, 7 reserved |
| lane_sz | input | 2 | Element width: 0 = 8, 1 = 16, 2 = 32, 3 reserved |
| sat_en | input | 1 | 1 = saturating add/sub, 0 = wraparound |
| signed_en | input | 1 | 1 = signed elements, 0 = unsigned |
| src_a | input | 64 | First source vector |
| src_b | input | 64 | Second source vector |
| out_valid | output | 1 | Result valid, one cycle after request |
| result | output | 64 | Registered result |

## Verification
The checker watches, on every cycle, the one-cycle timing of the valid flag and the holding of the result while idle. It also checks several properties that hold for any operands: equal sources compare as all ones, the reserved opcode gives zero, an all-ones operand under unsigned saturating add stays all ones, 8-bit compare results are whole-byte masks, and 32-bit unpack-low places the low words side by side. The exact values for carry isolation, signed and unsigned clamping, interleave order and the narrowing pack can only be shown by the bench's vectors. The bench's directed scenarios show the reset state.

// File: rtl/psalu_pkg.sv
package psalu_pkg;

    typedef enum logic [2:0] {
        OP_ADD   = 3'd0,
        OP_SUB   = 3'd1,
        OP_CMPEQ = 3'd2,
        OP_CMPGT = 3'd3,
        OP_UNPLO = 3'd4,
        OP_UNPHI = 3'd5,
        OP_PACK  = 3'd6,
        OP_RSVD  = 3'd7
    } op_e;

    localparam int OP_W = 3;
    localparam int SZ_W = 2;

endpackage

// File: rtl/psalu_lanes.sv
module psalu_lanes #(
    parameter int DATA_W = 64,
    parameter int LANE_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub_en,
    input  logic              sat_en,
    input  logic              sgn_en,
    output logic [DATA_W-1:0] arith,
    output logic [DATA_W-1:0] eq_mask,
    output logic [DATA_W-1:0] gt_mask
);
    localparam int NLANE = DATA_W / LANE_W;

    for (genvar i = 0; i < NLANE; i++) begin : g_lane
        logic [LANE_W-1:0] ea, eb, res;
        logic [LANE_W:0]   uwide, swide;
        logic              sovf, eq_b, gt_b;

        assign ea = a[i*LANE_W +: LANE_W];
        assign eb = b[i*LANE_W +: LANE_W];

        always_comb begin
            if (sub_en) begin
                uwide = {1'b0, ea} - {1'b0, eb};
                swide = {ea[LANE_W-1], ea} - {eb[LANE_W-1], eb};
            end else begin
                uwide = {1'b0, ea} + {1'b0, eb};
                swide = {ea[LANE_W-1], ea} + {eb[LANE_W-1], eb};
            end
            sovf = swide[LANE_W] ^ swide[LANE_W-1];
            res  = uwide[LANE_W-1:0];
            if (sat_en) begin
                if (sgn_en) begin
                    if (sovf) begin
                        res = swide[LANE_W] ? {1'b1, {(LANE_W-1){1'b0}}}
                                            : {1'b0, {(LANE_W-1){1'b1}}};
                    end
                end else if (uwide[LANE_W]) begin
                    res = sub_en ? '0 : '1;
                end
            end
            eq_b = (ea == eb);
            if (sgn_en) gt_b = ($signed(ea) > $signed(eb));
            else        gt_b = (ea > eb);
        end

        assign arith[i*LANE_W +: LANE_W]   = res;
        assign eq_mask[i*LANE_W +: LANE_W] = {LANE_W{eq_b}};
        assign gt_mask[i*LANE_W +: LANE_W] = {LANE_W{gt_b}};
    end

endmodule

// File: rtl/psalu_unpack.sv
module psalu_unpack #(
    parameter int DATA_W = 64,
    parameter int LANE_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              hi_en,
    output logic [DATA_W-1:0] res
);
    localparam int NLANE = DATA_W / LANE_W;
    localparam int HALF  = NLANE / 2;

    for (genvar k = 0; k < HALF; k++) begin : g_pair
        assign res[(2*k)*LANE_W +: LANE_W] =
            hi_en ? a[(HALF+k)*LANE_W +: LANE_W] : a[k*LANE_W +: LANE_W];
        assign res[(2*k+1)*LANE_W +: LANE_W] =
            hi_en ? b[(HALF+k)*LANE_W +: LANE_W] : b[k*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/psalu_pack.sv
module psalu_pack #(
    parameter int DATA_W = 64,
    parameter int SRC_W  = 16
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sgn_en,
    output logic [DATA_W-1:0] res
);
    localparam int NLANE = DATA_W / SRC_W;
    localparam int DST_W = SRC_W / 2;

    function automatic logic [DST_W-1:0] narrow(input logic [SRC_W-1:0] x,
                                                input logic sgn);
        logic [DST_W-1:0] y;
        if (sgn) begin
            // fits when all bits from the narrow sign bit upward agree
            if (x[SRC_W-1:DST_W-1] == '0 || x[SRC_W-1:DST_W-1] == '1)
                y = x[DST_W-1:0];
            else if (x[SRC_W-1])
                y = {1'b1, {(DST_W-1){1'b0}}};
            else
                y = {1'b0, {(DST_W-1){1'b1}}};
        end else begin
            if (x[SRC_W-1:DST_W] != '0) y = '1;
            else                        y = x[DST_W-1:0];
        end
        return y;
    endfunction

    for (genvar i = 0; i < NLANE; i++) begin : g_nar
        assign res[i*DST_W +: DST_W] =
            narrow(a[i*SRC_W +: SRC_W], sgn_en);
        assign res[(NLANE+i)*DST_W +: DST_W] =
            narrow(b[i*SRC_W +: SRC_W], sgn_en);
    end

endmodule

// File: rtl/psalu_top.sv
module psalu_top
    import psalu_pkg::*;
#(
    parameter int DATA_W     = 64,
    parameter int MIN_LANE_W = 8,
    parameter int NUM_SIZES  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   opcode,
    input  logic [SZ_W-1:0]   lane_sz,
    input  logic              sat_en,
    input  logic              signed_en,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic              out_valid,
    output logic [DATA_W-1:0] result
);
    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] res;
    } state_t;

    logic [DATA_W-1:0] arith_w [NUM_SIZES];
    logic [DATA_W-1:0] eq_w    [NUM_SIZES];
    logic [DATA_W-1:0] gt_w    [NUM_SIZES];
    logic [DATA_W-1:0] ulo_w   [NUM_SIZES];
    logic [DATA_W-1:0] uhi_w   [NUM_SIZES];
    logic [DATA_W-1:0] pk_w    [NUM_SIZES];
    logic              is_sub;

    assign is_sub = (opcode == OP_SUB);

    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
        localparam int LW = MIN_LANE_W << g;

        psalu_lanes #(.DATA_W(DATA_W), .LANE_W(LW)) u_lanes (
            .a(src_a), .b(src_b), .sub_en(is_sub), .sat_en(sat_en),
            .sgn_en(signed_en), .arith(arith_w[g]), .eq_mask(eq_w[g]),
            .gt_mask(gt_w[g])
        );

        psalu_unpack #(.DATA_W(DATA_W), .LANE_W(LW)) u_unlo (
            .a(src_a), .b(src_b), .hi_en(1'b0), .res(ulo_w[g])
        );

        psalu_unpack #(.DATA_W(DATA_W), .LANE_W(LW)) u_unhi (
            .a(src_a), .b(src_b), .hi_en(1'b1), .res(uhi_w[g])
        );

        if (g == 0) begin : g_nopack
            assign pk_w[g] = '0;
        end else begin : g_pack
            psalu_pack #(.DATA_W(DATA_W), .SRC_W(LW)) u_pack (
                .a(src_a), .b(src_b), .sgn_en(signed_en), .res(pk_w[g])
            );
        end
    end

    state_t            st_d, st_q;
    logic              sel_ok;
    logic [DATA_W-1:0] p_arith, p_eq, p_gt, p_ulo, p_uhi, p_pk, calc;

    always_comb begin
        sel_ok  = 1'b0;
        p_arith = '0;
        p_eq    = '0;
        p_gt    = '0;
        p_ulo   = '0;
        p_uhi   = '0;
        p_pk    = '0;
        for (int g = 0; g < NUM_SIZES; g++) begin
            if (int'(lane_sz) == g) begin
                sel_ok  = 1'b1;
                p_arith = arith_w[g];
                p_eq    = eq_w[g];
                p_gt    = gt_w[g];
                p_ulo   = ulo_w[g];
                p_uhi   = uhi_w[g];
                p_pk    = pk_w[g];
            end
        end

        calc = '0;
        if (sel_ok) begin
            case (opcode)
                OP_ADD, OP_SUB: calc = p_arith;
                OP_CMPEQ:       calc = p_eq;
                OP_CMPGT:       calc = p_gt;
                OP_UNPLO:       calc = p_ulo;
                OP_UNPHI:       calc = p_uhi;
                OP_PACK:        calc = p_pk;
                default:        calc = '0;
            endcase
        end

        st_d.vld = in_valid;
        st_d.res = in_valid ? calc : st_q.res;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.res;

endmodule

// File: rtl/psalu_chk.sv
module psalu_chk #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [2:0]        opcode,
    input logic [1:0]        lane_sz,
    input logic              sat_en,
    input logic              signed_en,
    input logic [DATA_W-1:0] src_a,
    input logic [DATA_W-1:0] src_b,
    input logic              out_valid,
    input logic [DATA_W-1:0] result
);
    localparam int HW = DATA_W / 2;

    function automatic logic byte_masks(input logic [DATA_W-1:0] v);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < DATA_W / 8; i++)
            if (v[i*8 +: 8] != 8'h00 && v[i*8 +: 8] != 8'hFF) ok = 1'b0;
        return ok;
    endfunction

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1
    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R1
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result)); // R2
    AST_USAT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 3'd0 && sat_en && !signed_en && lane_sz != 2'd3
         && src_a == '1) |=> result == '1); // R5
    AST_EQ_SELF: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 3'd2 && lane_sz != 2'd3 && src_a == src_b)
        |=> result == '1); // R6
    AST_BYTE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (opcode == 3'd2 || opcode == 3'd3) && lane_sz == 2'd0)
        |=> byte_masks(result)); // R7
    AST_UNPACK_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 3'd4 && lane_sz == 2'd2)
        |=> result == {$past(src_b[HW-1:0]), $past(src_a[HW-1:0])}); // R8
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (opcode == 3'd7 || lane_sz == 2'd3)) |=> result == '0); // R12

endmodule

bind psalu_top psalu_chk #(.DATA_W(DATA_W)) u_psalu_chk (.*);

// File: tb/test_psalu_top.sv
module test_psalu_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    typedef struct packed {
        logic [2:0]  op;
        logic [1:0]  sz;
        logic        sat;
        logic        sgn;
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NVEC = 18;
    localparam vec_t VECS [NVEC] = '{
        // R3 byte add wraps without carry into next byte
        '{3'd0, 2'd0, 1'b0, 1'b0, 64'h0000_0000_0000_00FF, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0000, 8'd3},
        // R3 same operands at 16 bits carry inside the lane
        '{3'd0, 2'd1, 1'b0, 1'b0, 64'h0000_0000_0000_00FF, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0100, 8'd3},
        // R3 32-bit subtract wraps, no borrow into upper word
        '{3'd1, 2'd2, 1'b0, 1'b0, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0001, 64'h0000_0000_FFFF_FFFF, 8'd3},
        // R4 signed byte add clamps both ways
        '{3'd0, 2'd0, 1'b1, 1'b1, 64'h0000_0000_0000_7F80, 64'h0000_0000_0000_01FF, 64'h0000_0000_0000_7F80, 8'd4},
        // R4 signed 32-bit subtract clamps both ways
        '{3'd1, 2'd2, 1'b1, 1'b1, 64'h8000_0000_7FFF_FFFF, 64'h0000_0001_FFFF_FFFE, 64'h8000_0000_7FFF_FFFF, 8'd4},
        // R5 unsigned 16-bit add clamps at all ones
        '{3'd0, 2'd1, 1'b1, 1'b0, 64'hFFFF_0001_0000_0000, 64'h0002_0001_0000_0000, 64'hFFFF_0002_0000_0000, 8'd5},
        // R5 unsigned byte subtract clamps at zero
        '{3'd1, 2'd0, 1'b1, 1'b0, 64'h0000_0000_0030_0510, 64'h0000_0000_0010_0620, 64'h0000_0000_0020_0000, 8'd5},
        // R6 16-bit equality masks
        '{3'd2, 2'd1, 1'b0, 1'b0, 64'h1234_5678_9ABC_DEF0, 64'h1234_0000_9ABC_0000, 64'hFFFF_0000_FFFF_0000, 8'd6},
        // R7 signed byte greater-than
        '{3'd3, 2'd0, 1'b0, 1'b1, 64'h0000_0000_0000_0180, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_FF00, 8'd7},
        // R7 unsigned byte greater-than
        '{3'd3, 2'd0, 1'b0, 1'b0, 64'h0000_0000_0000_0180, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_FFFF, 8'd7},
        // R8 byte unpack-low interleave
        '{3'd4, 2'd0, 1'b0, 1'b0, 64'h0706_0504_0302_0100, 64'h1716_1514_1312_1110, 64'h1303_1202_1101_1000, 8'd8},
        // R8 word unpack-low
        '{3'd4, 2'd2, 1'b0, 1'b0, 64'hAAAA_AAAA_1111_1111, 64'hBBBB_BBBB_2222_2222, 64'h2222_2222_1111_1111, 8'd8},
        // R9 16-bit unpack-high interleave
        '{3'd5, 2'd1, 1'b0, 1'b0, 64'h0003_0002_0001_0000, 64'h0013_0012_0011_0010, 64'h0013_0003_0012_0002, 8'd9},
        // R10 signed pack 16 to 8
        '{3'd6, 2'd1, 1'b0, 1'b1, 64'h7FFF_8000_0005_FFFF, 64'h0100_FF00_0010_0000, 64'h7F80_1000_7F80_05FF, 8'd10},
        // R11 unsigned pack 32 to 16
        '{3'd6, 2'd2, 1'b0, 1'b0, 64'h0001_0000_0000_1234, 64'h0000_0000_0000_FFFF, 64'h0000_FFFF_FFFF_1234, 8'd11},
        // R12 reserved opcode
        '{3'd7, 2'd0, 1'b0, 1'b0, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 64'h0000_0000_0000_0000, 8'd12},
        // R12 reserved lane size
        '{3'd0, 2'd3, 1'b0, 1'b0, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 64'h0000_0000_0000_0000, 8'd12},
        // R12 pack with byte lanes
        '{3'd6, 2'd0, 1'b0, 1'b1, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 64'h0000_0000_0000_0000, 8'd12}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  opcode = '0;
    logic [1:0]  lane_sz = '0;
    logic        sat_en = 1'b0;
    logic        signed_en = 1'b0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic        out_valid;
    logic [63:0] result;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    psalu_top i_psalu_top (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
        .lane_sz(lane_sz), .sat_en(sat_en), .signed_en(signed_en),
        .src_a(src_a), .src_b(src_b), .out_valid(out_valid), .result(result)
    );

    task automatic check(input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            bad++;
            total++;
            $display("FAIL R1 watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R13: reset state
        repeat (2) @(negedge clk);
        check("R13 reset valid", {63'd0, out_valid}, 64'd0);
        check("R13 reset result", result, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            opcode    = VECS[i].op;
            lane_sz   = VECS[i].sz;
            sat_en    = VECS[i].sat;
            signed_en = VECS[i].sgn;
            src_a     = VECS[i].a;
            src_b     = VECS[i].b;
            in_valid  = 1'b1;
            @(negedge clk);
            check($sformatf("R%0d vector %0d", VECS[i].req, i), result, VECS[i].exp);
            check($sformatf("R1 valid vector %0d", i), {63'd0, out_valid}, 64'd1);
        end

        // R2: idle inputs change, result holds
        opcode = 3'd0; lane_sz = 2'd1; sat_en = 1'b0; signed_en = 1'b0;
        src_a = 64'h0000_0000_0000_0001; src_b = 64'h0000_0000_0000_0002;
        in_valid = 1'b1;
        @(negedge clk);
        check("R3 setup for hold", result, 64'h0000_0000_0000_0003);
        in_valid = 1'b0;
        src_a = 64'hFFFF_FFFF_FFFF_FFFF; opcode = 3'd2;
        @(negedge clk);
        check("R1 idle valid low", {63'd0, out_valid}, 64'd0);
        check("R2 hold after one idle", result, 64'h0000_0000_0000_0003);
        src_b = 64'h1234_0000_0000_0000;
        @(negedge clk);
        check("R2 hold after two idle", result, 64'h0000_0000_0000_0003);

        // R13: reset during operation clears state
        rst_n = 1'b0;
        @(negedge clk);
        check("R13 mid reset result", result, 64'd0);
        check("R13 mid reset valid", {63'd0, out_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule